// File: doc/BRIEF.md
# Prescaled PWM Channel

This block produces one pulse-width-modulated output from four software-visible registers: control, prescale, period and duty. A counting tick is made by dividing one of two clock-enable strobes by (prescale + 1). The strobes are a fast core strobe and a low-frequency strobe, and both live in the block's single clock domain. A PWM cycle lasts (period + 1) ticks. The output is active for the first (duty + 1) ticks of each cycle. It stays inactive for the whole cycle when the duty value exceeds the period value.

Prescale, period and duty are copied into working copies only while the channel is stopped or at a cycle boundary, so a write made mid-cycle never cuts a pulse short. A sequencer state machine has four states. IDLE is stopped and tracks the registers. ARMED is enabled and waits for the first tick. DRIVE is the active phase. QUIET is the inactive phase. Its transitions are:
- start: IDLE to ARMED when enable is set.
- launch: ARMED to DRIVE, or to QUIET when duty exceeds period, on the first tick.
- duty end: DRIVE to QUIET on the tick that ends interval `duty`.
- wrap: DRIVE or QUIET to DRIVE or QUIET at the cycle boundary, decided by the newly loaded values.
- stop: any state to IDLE when enable is cleared.

Top module: `pwm_channel`

## Requirements
- R1: After reset, all four registers read back as follows: control 0, prescale 0, period 0, duty 0xFFFF. The output is 0.
- R2: Writing address a with wr_en stores wr_data, and reading address a returns it. Address 0 is control, with enable at bit 0, invert at bit 1, clock select at bit 2 and heartbeat at bits 4:3; the other control bits read 0. Address 1 is prescale, address 2 is period, address 3 is duty.
- R3: One tick occurs for every (prescale + 1) selected strobes.
- R4: Each cycle is (period + 1) ticks long. When duty ≤ period the output is active for (duty + 1) ticks of each cycle, so duty 0 gives one tick and duty = period gives a constant active level.
- R5: When duty > period the output is inactive for the whole cycle.
- R6: Clearing enable makes the output inactive by the second clock edge after the write, and it stays inactive while enable is clear.
- R7: With invert set, the active level is 0 and the inactive level is 1, including while stopped.
- R8: Clock select 1 counts the low-frequency strobe and clock select 0 counts the core strobe.
- R9: The heartbeat field is stored and read back but does not change the output.
- R10: A duty, period or prescale write made during a cycle takes effect only at the next cycle boundary.
- R11: On enable the counters restart from zero. The first active phase begins at the first tick, which falls (prescale + 2) clock edges after the edge that wrote enable, when the core strobe is selected and held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_stb | input | 1 | Fast clock-enable strobe |
| slow_stb | input | 1 | Low-frequency clock-enable strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data for rd_addr (combinational) |
| pwm_out | output | 1 | PWM output after polarity |

## Verification
The duty value is swept over 0, mid-range, equal to the period and above the period, with both polarities. Active clocks are counted over a window of whole cycles, which separates the one-tick minimum, the proportional case, the constant-active case and the forced-off case. Prescaled runs on the core strobe and runs on the slow strobe give different expected counts, so a wrong divider or a wrong strobe choice shows up. Directed timing runs measure the enable-to-first-pulse latency and the length of a pulse whose duty was rewritten mid-pulse, which tells boundary loading apart from immediate loading.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADR_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_PRESC  = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_PERIOD = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_DUTY   = 2'd3;

    localparam int BIT_EN  = 0;
    localparam int BIT_INV = 1;
    localparam int BIT_SEL = 2;
    localparam int BIT_HB  = 3;
    localparam int CTRL_W  = 5;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ARMED = 2'd1,
        SQ_DRIVE = 2'd2,
        SQ_QUIET = 2'd3
    } seq_state_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CW-1:0]     rd_data,
    output logic              en,
    output logic              inv,
    output logic              clksel,
    output logic [CW-1:0]     presc,
    output logic [CW-1:0]     period,
    output logic [CW-1:0]     duty
);
    logic [CTRL_W-1:0] ctrl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            presc  <= '0;
            period <= '0;
            duty   <= '1;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADR_CTRL:   ctrl_q <= wr_data[CTRL_W-1:0];
                ADR_PRESC:  presc  <= wr_data;
                ADR_PERIOD: period <= wr_data;
                ADR_DUTY:   duty   <= wr_data;
                default:    ;
            endcase
        end
    end

    assign en     = ctrl_q[BIT_EN];
    assign inv    = ctrl_q[BIT_INV];
    assign clksel = ctrl_q[BIT_SEL];

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADR_CTRL:   rd_data[CTRL_W-1:0] = ctrl_q;
            ADR_PRESC:  rd_data = presc;
            ADR_PERIOD: rd_data = period;
            ADR_DUTY:   rd_data = duty;
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          core_stb,
    input  logic          slow_stb,
    input  logic          clksel,
    input  logic [CW-1:0] limit,
    output logic          tick
);
    logic [CW-1:0] div_q;
    logic          src_stb;

    assign src_stb = clksel ? slow_stb : core_stb;
    assign tick    = run && src_stb && (div_q == limit);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_q <= '0;
        end else if (src_stb) begin
            div_q <= (div_q == limit) ? '0 : div_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_sequencer.sv
module pwm_sequencer
    import pwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          tick,
    input  logic [CW-1:0] presc_in,
    input  logic [CW-1:0] period_in,
    input  logic [CW-1:0] duty_in,
    output logic          counting,
    output logic          active,
    output logic          cyc_end,
    output logic [CW-1:0] sh_presc,
    output logic [CW-1:0] sh_period,
    output logic [CW-1:0] sh_duty,
    output logic [CW-1:0] pos
);
    seq_state_t state_q, state_d;
    logic       load_sh;
    logic       cur_ok, new_ok;

    assign cur_ok  = (sh_duty <= sh_period);
    assign new_ok  = (duty_in <= period_in);
    assign cyc_end = tick && (state_q == SQ_DRIVE || state_q == SQ_QUIET)
                     && (pos == sh_period);
    assign load_sh = (state_q == SQ_IDLE) || cyc_end;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = SQ_IDLE;
        end else begin
            unique case (state_q)
                SQ_IDLE:  state_d = SQ_ARMED;
                SQ_ARMED: if (tick) state_d = cur_ok ? SQ_DRIVE : SQ_QUIET;
                SQ_DRIVE: begin
                    if (cyc_end)                    state_d = new_ok ? SQ_DRIVE : SQ_QUIET;
                    else if (tick && pos == sh_duty) state_d = SQ_QUIET;
                end
                SQ_QUIET: if (cyc_end) state_d = new_ok ? SQ_DRIVE : SQ_QUIET;
                default:  state_d = SQ_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        counting = (state_q != SQ_IDLE);
        active   = (state_q == SQ_DRIVE);
    end

    // tick position in the cycle
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == SQ_IDLE || state_q == SQ_ARMED) begin
            pos <= '0;
        end else if (tick) begin
            pos <= cyc_end ? '0 : pos + 1'b1;
        end
    end

    // working copies
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_presc  <= '0;
            sh_period <= '0;
            sh_duty   <= '1;
        end else if (load_sh) begin
            sh_presc  <= presc_in;
            sh_period <= period_in;
            sh_duty   <= duty_in;
        end
    end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_stb,
    input  logic              slow_stb,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CW-1:0]     rd_data,
    output logic              pwm_out
);
    logic          en, inv, clksel;
    logic [CW-1:0] presc, period, duty;
    logic          tick, counting, active, cyc_end;
    logic [CW-1:0] sh_presc, sh_period, sh_duty, pos;

    pwm_regs #(.CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .en(en), .inv(inv), .clksel(clksel),
        .presc(presc), .period(period), .duty(duty)
    );

    pwm_prescaler #(.CW(CW)) u_div (
        .clk(clk), .rst_n(rst_n), .run(counting),
        .core_stb(core_stb), .slow_stb(slow_stb), .clksel(clksel),
        .limit(sh_presc), .tick(tick)
    );

    pwm_sequencer #(.CW(CW)) u_seq (
        .clk(clk), .rst_n(rst_n), .enable(en), .tick(tick),
        .presc_in(presc), .period_in(period), .duty_in(duty),
        .counting(counting), .active(active), .cyc_end(cyc_end),
        .sh_presc(sh_presc), .sh_period(sh_period), .sh_duty(sh_duty),
        .pos(pos)
    );

    assign pwm_out = active ^ inv;
endmodule

// File: rtl/pwm_channel_chk.sv
module pwm_channel_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          core_stb,
    input logic          slow_stb,
    input logic          en,
    input logic          inv,
    input logic          clksel,
    input logic          tick,
    input logic          counting,
    input logic          active,
    input logic          cyc_end,
    input logic [CW-1:0] sh_presc,
    input logic [CW-1:0] sh_period,
    input logic [CW-1:0] sh_duty,
    input logic [CW-1:0] pos,
    input logic          pwm_out
);
    assert_tick_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (clksel ? slow_stb : core_stb));

    assert_pos_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        counting |-> (pos <= sh_period));

    assert_over_range_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && (sh_duty > sh_period)) |-> !active);

    assert_stop_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !active);

    assert_idle_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !counting |-> (pwm_out == inv));

    assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && !cyc_end) |=>
            ($stable(sh_duty) && $stable(sh_period) && $stable(sh_presc)));
endmodule

bind pwm_channel pwm_channel_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .core_stb(core_stb), .slow_stb(slow_stb),
    .en(en), .inv(inv), .clksel(clksel), .tick(tick),
    .counting(counting), .active(active), .cyc_end(cyc_end),
    .sh_presc(sh_presc), .sh_period(sh_period), .sh_duty(sh_duty),
    .pos(pos), .pwm_out(pwm_out)
);

// File: tb/pwm_channel_test.sv
module pwm_channel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_stb = 1'b1;
    logic        slow_stb = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        pwm_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    pwm_channel uut (
        .clk(clk), .rst_n(rst_n), .core_stb(core_stb), .slow_stb(slow_stb),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out)
    );

    always #5 clk = ~clk;

    // slow strobe: one pulse every 4 clocks
    initial begin
        int sc = 0;
        forever begin
            @(negedge clk);
            sc++;
            slow_stb = (sc % 4 == 0);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input logic [1:0] a, input logic [15:0] exp, input string req);
        @(negedge clk);
        rd_addr = a;
        #1;
        check(rd_data == exp, req, rd_data, exp);
    endtask

    function automatic logic [15:0] ctrl_word(bit en, bit inv, bit sel, logic [1:0] hb);
        return {11'd0, hb, sel, inv, en};
    endfunction

    // program, enable, then count active clocks over 3 whole cycles
    task automatic run_duty(input int presc, input int per, input int duty, input bit inv,
                            input bit sel, input logic [1:0] hb, input string req);
        int mult = sel ? 4 : 1;
        int win = 3 * (per + 1) * (presc + 1) * mult;
        int exp = (duty <= per) ? 3 * (duty + 1) * (presc + 1) * mult : 0;
        int act = 0;
        wr(2'd0, 16'd0);
        wr(2'd1, 16'(presc));
        wr(2'd2, 16'(per));
        wr(2'd3, 16'(duty));
        wr(2'd0, ctrl_word(1'b1, inv, sel, hb));
        repeat ((presc + 1) * mult + 4) @(negedge clk);
        for (int i = 0; i < win; i++) begin
            if (pwm_out != inv) act++;
            @(negedge clk);
        end
        check(act == exp, req, act, exp);
    endtask

    task automatic t_reset();
        rd_check(2'd0, 16'h0000, "R1 ctrl");
        rd_check(2'd1, 16'h0000, "R1 prescale");
        rd_check(2'd2, 16'h0000, "R1 period");
        rd_check(2'd3, 16'hFFFF, "R1 duty");
        check(pwm_out == 1'b0, "R1 out", pwm_out, 0);
    endtask

    task automatic t_readback();
        wr(2'd0, 16'hFFFE);
        rd_check(2'd0, 16'h001E, "R2 ctrl");
        @(negedge clk);
        check(pwm_out == 1'b1, "R7 stopped inverted level", pwm_out, 1);
        wr(2'd1, 16'h1234);
        rd_check(2'd1, 16'h1234, "R2 prescale");
        wr(2'd2, 16'hABCD);
        rd_check(2'd2, 16'hABCD, "R2 period");
        wr(2'd3, 16'h00C3);
        rd_check(2'd3, 16'h00C3, "R2 duty");
        wr(2'd0, 16'h0000);
    endtask

    task automatic t_duty();
        for (int p = 0; p < 2; p++) begin
            run_duty(1, 9, 0,  p[0], 1'b0, 2'd0, "R4 duty zero");
            run_duty(1, 9, 4,  p[0], 1'b0, 2'd0, "R4 duty mid");
            run_duty(1, 9, 9,  p[0], 1'b0, 2'd0, "R4 duty equal period");
            run_duty(1, 9, 12, p[0], 1'b0, 2'd0, "R5 duty above period");
        end
        run_duty(0, 3, 2, 1'b1, 1'b0, 2'd0, "R7 inverted polarity");
    endtask

    task automatic t_prescale();
        run_duty(4, 3, 1, 1'b0, 1'b0, 2'd0, "R3 prescale 4");
        run_duty(0, 5, 3, 1'b0, 1'b0, 2'd0, "R3 prescale 0");
    endtask

    task automatic t_slow();
        run_duty(1, 4, 2, 1'b0, 1'b1, 2'd0, "R8 slow strobe");
    endtask

    task automatic t_heartbeat();
        run_duty(1, 6, 2, 1'b0, 1'b0, 2'd2, "R9 heartbeat ignored");
    endtask

    task automatic t_disable();
        int bad = 0;
        run_duty(0, 3, 3, 1'b0, 1'b0, 2'd0, "R4 constant active");
        wr(2'd0, ctrl_word(1'b0, 1'b0, 1'b0, 2'd0));
        @(negedge clk);
        check(pwm_out == 1'b0, "R6 off after disable", pwm_out, 0);
        for (int i = 0; i < 20; i++) begin
            if (pwm_out != 1'b0) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R6 held off", bad, 0);
    endtask

    task automatic t_restart();
        int n;
        wr(2'd0, 16'd0);
        wr(2'd1, 16'd3);
        wr(2'd2, 16'd5);
        wr(2'd3, 16'd2);
        for (int k = 0; k < 2; k++) begin
            wr(2'd0, ctrl_word(1'b1, 1'b0, 1'b0, 2'd0));
            n = 0;
            do begin
                @(negedge clk);
                n++;
            end while (!pwm_out && n < 60);
            check(n == 5, "R11 first pulse latency", n, 5);
            repeat (7) @(negedge clk);
            wr(2'd0, 16'd0);
        end
    endtask

    task automatic t_shadow();
        int run_len, n;
        wr(2'd0, 16'd0);
        wr(2'd1, 16'd0);
        wr(2'd2, 16'd19);
        wr(2'd3, 16'd9);
        wr(2'd0, ctrl_word(1'b1, 1'b0, 1'b0, 2'd0));
        n = 0;
        while (!pwm_out && n < 100) begin @(negedge clk); n++; end
        // first active sample seen; rewrite duty mid-pulse
        run_len = 1;
        wr_en = 1'b1; wr_addr = 2'd3; wr_data = 16'd2;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        while (pwm_out && run_len < 100) begin run_len++; @(negedge clk); end
        check(run_len == 10, "R10 current pulse keeps old duty", run_len, 10);
        n = 0;
        while (!pwm_out && n < 100) begin @(negedge clk); n++; end
        run_len = 0;
        while (pwm_out && run_len < 100) begin run_len++; @(negedge clk); end
        check(run_len == 3, "R10 next pulse uses new duty", run_len, 3);
        wr(2'd0, 16'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_readback();
        t_duty();
        t_prescale();
        t_slow();
        t_heartbeat();
        t_disable();
        t_restart();
        t_shadow();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule